// File: doc/BRIEF.md
# Multi-Size Page Translation Buffer

This block is a small, fully associative cache of address translations. Every slot holds a virtual tag, a physical base, a permission field, a domain number and a page-kind code. The page kind sets the slot's own compare mask, so slots of different page sizes can sit side by side. Page kinds run from a 1 KiB tiny page through 4 KiB and 64 KiB pages up to a 1 MiB section.

A lookup is purely combinational. It takes a 32-bit virtual address and returns hit, the index of the winning slot, that slot's fields and the translated physical address. A registered copy of hit follows one cycle later. New translations enter through a fill port, which writes the slot named by a rotating victim pointer. Two maintenance commands are provided: flush-all, and drop-by-address. Table walking and permission checking belong to the surrounding logic.

Top module: `page_tlb`

## Requirements
- R1: After reset every slot is invalid, so no lookup hits, `lk_hit_q` is 0 and the next fill lands in slot 0.
- R2: Page-kind codes and compare masks are: 1 = 4 KiB (0xFFFFF000), 2 = 64 KiB (0xFFFF0000), 3 = 1 MiB section (0xFFF00000), 4 = extended 4 KiB (0xFFFFF000), 5 = 1 KiB tiny (0xFFFFFC00). A slot with a valid kind hits when the lookup address ANDed with its mask equals its stored tag.
- R3: Kind code 0 means invalid, and codes 6 and 7 are stored as 0. An invalid slot never hits.
- R4: A fill stores the virtual tag and the physical base each ANDed with the new kind's mask. It stores the permission field, the domain and the kind unchanged. A lookup hit returns the stored permission, domain and kind.
- R5: On a hit, `lk_paddr` equals the stored base OR'd with the lookup address ANDed with the inverse of the mask.
- R6: Each fill writes the slot named by the victim pointer. The pointer then advances by one and wraps from ENTRIES-1 to 0.
- R7: Flush-all makes every slot invalid and returns the victim pointer to 0. If a fill arrives in the same cycle, the flush wins and the fill is dropped.
- R8: Drop-by-address invalidates only the lowest-index slot that matches `inv_addr`. It leaves the victim pointer unchanged.
- R9: When several slots match a lookup, the lowest index wins.
- R10: `lk_hit_q` equals the value `lk_hit` had one cycle earlier.
- R11: If a fill and a drop-by-address target the same slot in one cycle, the fill wins and the slot holds the new entry.
- R12: On a miss, `lk_slot`, `lk_paddr`, `lk_perm`, `lk_dom` and `lk_kind` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Combinational lookup hit |
| lk_slot | output | $clog2(ENTRIES) | Index of the winning slot |
| lk_paddr | output | 32 | Translated physical address |
| lk_perm | output | PERM_W | Permission field of the winning slot |
| lk_dom | output | DOM_W | Domain of the winning slot |
| lk_kind | output | 3 | Page kind of the winning slot |
| lk_hit_q | output | 1 | lk_hit delayed by one cycle |
| fill_en | input | 1 | Write a new entry at the victim slot |
| fill_vaddr | input | 32 | Virtual address of the new entry |
| fill_pbase | input | 32 | Physical base of the new entry |
| fill_perm | input | PERM_W | Permission field of the new entry |
| fill_dom | input | DOM_W | Domain of the new entry |
| fill_kind | input | 3 | Page kind of the new entry |
| inv_all | input | 1 | Flush every slot |
| inv_addr_en | input | 1 | Drop the slot matching inv_addr |
| inv_addr | input | 32 | Address for drop-by-address |

## Verification
The assertions take the inputs as already settled at each rising edge. They also take a fill and a flush in the same cycle as legal, with a fixed outcome, not as something to forbid. The victim-pointer properties assume a pointer value outside 0..ENTRIES-1 cannot arise, and the rotor guarantees this. The stimulus drives inputs only on falling edges. It mixes directed sequences (overlapping page sizes, same-cycle command collisions, unknown kind codes) with a seeded random phase. That phase draws addresses from a narrow pool so that hits, multiple matches and drops of live slots all occur often.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;
   localparam int ADDR_W = 32;
   typedef logic [2:0] kind_t;
   localparam kind_t KIND_NONE   = 3'd0;
   localparam kind_t KIND_4K     = 3'd1;
   localparam kind_t KIND_64K    = 3'd2;
   localparam kind_t KIND_1M     = 3'd3;
   localparam kind_t KIND_4K_EXT = 3'd4;
   localparam kind_t KIND_1K     = 3'd5;

   function automatic logic kind_live(input kind_t k);
      return (k >= KIND_4K) && (k <= KIND_1K);
   endfunction

   function automatic logic [ADDR_W-1:0] kind_mask(input kind_t k);
      case (k)
         KIND_4K, KIND_4K_EXT: return 32'hFFFF_F000;
         KIND_64K:             return 32'hFFFF_0000;
         KIND_1M:              return 32'hFFF0_0000;
         KIND_1K:              return 32'hFFFF_FC00;
         default:              return 32'h0000_0000;
      endcase
   endfunction
endpackage

// File: rtl/tlb_rotor.sv
module tlb_rotor #(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          step,
   output logic [IW-1:0] ptr
);
   localparam logic [IW-1:0] LAST = IW'(N - 1);

   always_ff @(posedge clk) begin
      if (!rst_n || clear)
         ptr <= '0;
      else if (step)
         ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
   end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--)
         if (req[i]) idx = IW'(i);
   end
   assign any = |req;
endmodule

// File: rtl/tlb_entry.sv
module tlb_entry
   import tlbm_pkg::*;
#(
   parameter int PERM_W = 10,
   parameter int DOM_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              clr,
   input  logic [ADDR_W-1:0] w_va,
   input  logic [ADDR_W-1:0] w_pa,
   input  logic [PERM_W-1:0] w_perm,
   input  logic [DOM_W-1:0]  w_dom,
   input  kind_t             w_kind,
   input  logic [ADDR_W-1:0] lk_va,
   input  logic [ADDR_W-1:0] iv_va,
   output logic              lk_match,
   output logic              iv_match,
   output logic [ADDR_W-1:0] o_pbase,
   output logic [PERM_W-1:0] o_perm,
   output logic [DOM_W-1:0]  o_dom,
   output kind_t             o_kind
);
   logic [ADDR_W-1:0] tag_q;
   logic [ADDR_W-1:0] wmask;
   logic [ADDR_W-1:0] smask;
   logic              live;

   assign wmask = kind_mask(w_kind);
   assign smask = kind_mask(o_kind);
   assign live  = kind_live(o_kind);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         o_kind  <= KIND_NONE;
         tag_q   <= '0;
         o_pbase <= '0;
         o_perm  <= '0;
         o_dom   <= '0;
      end else if (wr) begin
         o_kind  <= kind_live(w_kind) ? w_kind : KIND_NONE;
         tag_q   <= w_va & wmask;
         o_pbase <= w_pa & wmask;
         o_perm  <= w_perm;
         o_dom   <= w_dom;
      end else if (clr) begin
         o_kind  <= KIND_NONE;
      end
   end

   assign lk_match = live && (((lk_va ^ tag_q) & smask) == '0);
   assign iv_match = live && (((iv_va ^ tag_q) & smask) == '0);
endmodule

// File: rtl/page_tlb.sv
module page_tlb
   import tlbm_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int PERM_W  = 10,
   parameter int DOM_W   = 4,
   localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] lk_vaddr,
   output logic              lk_hit,
   output logic [IW-1:0]     lk_slot,
   output logic [ADDR_W-1:0] lk_paddr,
   output logic [PERM_W-1:0] lk_perm,
   output logic [DOM_W-1:0]  lk_dom,
   output logic [2:0]        lk_kind,
   output logic              lk_hit_q,
   input  logic              fill_en,
   input  logic [ADDR_W-1:0] fill_vaddr,
   input  logic [ADDR_W-1:0] fill_pbase,
   input  logic [PERM_W-1:0] fill_perm,
   input  logic [DOM_W-1:0]  fill_dom,
   input  logic [2:0]        fill_kind,
   input  logic              inv_all,
   input  logic              inv_addr_en,
   input  logic [ADDR_W-1:0] inv_addr
);
   if (ENTRIES < 2) begin : g_bad_entries
      $error("page_tlb: ENTRIES must be at least 2");
   end
   if (PERM_W < 1 || DOM_W < 1) begin : g_bad_fields
      $error("page_tlb: PERM_W and DOM_W must be positive");
   end

   logic [IW-1:0]     victim;
   logic [ENTRIES-1:0] lk_req, iv_req, wr_vec, clr_vec;
   logic              iv_any;
   logic [IW-1:0]     iv_idx;
   logic              lk_any;
   logic [IW-1:0]     lk_idx;
   logic [ADDR_W-1:0] e_pbase [ENTRIES];
   logic [PERM_W-1:0] e_perm  [ENTRIES];
   logic [DOM_W-1:0]  e_dom   [ENTRIES];
   kind_t             e_kind  [ENTRIES];

   tlb_rotor #(.N(ENTRIES), .IW(IW)) u_rotor (
      .clk(clk), .rst_n(rst_n), .clear(inv_all),
      .step(fill_en), .ptr(victim)
   );

   tlb_pick #(.N(ENTRIES), .IW(IW)) u_pick_lk (
      .req(lk_req), .any(lk_any), .idx(lk_idx)
   );

   tlb_pick #(.N(ENTRIES), .IW(IW)) u_pick_iv (
      .req(iv_req), .any(iv_any), .idx(iv_idx)
   );

   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      assign wr_vec[g]  = fill_en && !inv_all && (victim == IW'(g));
      assign clr_vec[g] = inv_all || (inv_addr_en && iv_any && (iv_idx == IW'(g)));

      tlb_entry #(.PERM_W(PERM_W), .DOM_W(DOM_W)) u_entry (
         .clk(clk), .rst_n(rst_n),
         .wr(wr_vec[g]), .clr(clr_vec[g]),
         .w_va(fill_vaddr), .w_pa(fill_pbase), .w_perm(fill_perm),
         .w_dom(fill_dom), .w_kind(fill_kind),
         .lk_va(lk_vaddr), .iv_va(inv_addr),
         .lk_match(lk_req[g]), .iv_match(iv_req[g]),
         .o_pbase(e_pbase[g]), .o_perm(e_perm[g]),
         .o_dom(e_dom[g]), .o_kind(e_kind[g])
      );
   end

   always_comb begin
      lk_hit   = lk_any;
      lk_slot  = '0;
      lk_paddr = '0;
      lk_perm  = '0;
      lk_dom   = '0;
      lk_kind  = KIND_NONE;
      if (lk_any) begin
         lk_slot  = lk_idx;
         lk_kind  = e_kind[lk_idx];
         lk_perm  = e_perm[lk_idx];
         lk_dom   = e_dom[lk_idx];
         lk_paddr = e_pbase[lk_idx] | (lk_vaddr & ~kind_mask(e_kind[lk_idx]));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) lk_hit_q <= 1'b0;
      else        lk_hit_q <= lk_hit;
   end
endmodule

// File: rtl/page_tlb_chk.sv
module page_tlb_chk
   import tlbm_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int IW      = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] lk_vaddr,
   input logic              lk_hit,
   input logic [ADDR_W-1:0] lk_paddr,
   input logic [2:0]        lk_kind,
   input logic              lk_hit_q,
   input logic              fill_en,
   input logic              inv_all,
   input logic              inv_addr_en,
   input logic [IW-1:0]     victim
);
   assert_offset_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (((lk_paddr ^ lk_vaddr) & ~kind_mask(lk_kind)) == '0));

   assert_live_kind_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (lk_kind >= 3'd1 && lk_kind <= 3'd5));

   assert_miss_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_paddr == '0 && lk_kind == 3'd0));

   assert_hit_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (lk_hit_q == $past(lk_hit)));

   assert_rotate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && !inv_all) |=>
         (victim == (($past(victim) == IW'(ENTRIES - 1)) ? '0 : $past(victim) + 1'b1)));

   assert_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
      inv_all |=> (victim == '0 && !lk_hit));

   assert_drop_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_addr_en && !fill_en && !inv_all) |=> $stable(victim));
endmodule

bind page_tlb page_tlb_chk #(.ENTRIES(ENTRIES), .IW(IW)) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit),
   .lk_paddr(lk_paddr), .lk_kind(lk_kind), .lk_hit_q(lk_hit_q),
   .fill_en(fill_en), .inv_all(inv_all), .inv_addr_en(inv_addr_en),
   .victim(victim)
);

// File: tb/page_tlb_bench.sv
module page_tlb_bench;
   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] lk_vaddr = '0;
   logic        lk_hit;
   logic [2:0]  lk_slot;
   logic [31:0] lk_paddr;
   logic [9:0]  lk_perm;
   logic [3:0]  lk_dom;
   logic [2:0]  lk_kind;
   logic        lk_hit_q;
   logic        fill_en = 1'b0;
   logic [31:0] fill_vaddr = '0, fill_pbase = '0;
   logic [9:0]  fill_perm = '0;
   logic [3:0]  fill_dom = '0;
   logic [2:0]  fill_kind = '0;
   logic        inv_all = 1'b0, inv_addr_en = 1'b0;
   logic [31:0] inv_addr = '0;

   always #2 clk = ~clk;

   page_tlb #(.ENTRIES(N)) u_page_tlb (.*);

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;
   string phase = "R1";

   bit [31:0] m_tag [N], m_pb [N];
   int        m_perm [N], m_dom [N], m_kind [N];
   int        m_ptr = 0;
   bit        exp_hq = 1'b0;

   function automatic bit [31:0] bmask(int k);
      if (k == 1 || k == 4) return 32'hFFFF_F000;
      if (k == 2) return 32'hFFFF_0000;
      if (k == 3) return 32'hFFF0_0000;
      if (k == 5) return 32'hFFFF_FC00;
      return 32'h0;
   endfunction

   function automatic int find(bit [31:0] a);
      for (int i = 0; i < N; i++)
         if (m_kind[i] >= 1 && m_kind[i] <= 5 &&
             (a & bmask(m_kind[i])) == (m_tag[i] & bmask(m_kind[i])))
            return i;
      return -1;
   endfunction

   task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s (phase %s) actual=%h expected=%h", rq, what, phase, act, exp);
      end
   endtask

   task automatic cycle();
      int e;
      bit [31:0] m;
      #1;
      e = find(lk_vaddr);
      chk("R2", "hit", 32'(lk_hit), 32'(e >= 0));
      chk("R10", "hit_q", 32'(lk_hit_q), 32'(exp_hq));
      if (e >= 0) begin
         m = bmask(m_kind[e]);
         chk("R9", "slot", 32'(lk_slot), 32'(e));
         chk("R5", "paddr", lk_paddr, m_pb[e] | (lk_vaddr & ~m));
         chk("R4", "perm", 32'(lk_perm), 32'(m_perm[e]));
         chk("R4", "dom", 32'(lk_dom), 32'(m_dom[e]));
         chk("R4", "kind", 32'(lk_kind), 32'(m_kind[e]));
      end else begin
         chk("R12", "miss fields", {lk_paddr ^ {22'd0, lk_perm}}, 32'h0);
         chk("R12", "miss slot/dom/kind", {22'd0, lk_slot, lk_dom, lk_kind}, 32'h0);
      end
      @(posedge clk);
      exp_hq = (e >= 0);
      if (inv_all) begin
         for (int i = 0; i < N; i++) m_kind[i] = 0;
         m_ptr = 0;
      end else begin
         int iv;
         iv = inv_addr_en ? find(inv_addr) : -1;
         if (iv >= 0) m_kind[iv] = 0;
         if (fill_en) begin
            int k;
            k = int'(fill_kind);
            m = bmask(k);
            m_kind[m_ptr] = (k >= 1 && k <= 5) ? k : 0;
            m_tag[m_ptr]  = fill_vaddr & m;
            m_pb[m_ptr]   = fill_pbase & m;
            m_perm[m_ptr] = int'(fill_perm);
            m_dom[m_ptr]  = int'(fill_dom);
            m_ptr = (m_ptr + 1) % N;
         end
      end
      @(negedge clk);
   endtask

   task automatic look(bit [31:0] a);
      lk_vaddr = a;
      cycle();
   endtask

   task automatic fill(bit [31:0] va, bit [31:0] pa, bit [9:0] pm, bit [3:0] dm, bit [2:0] k);
      fill_en = 1'b1; fill_vaddr = va; fill_pbase = pa;
      fill_perm = pm; fill_dom = dm; fill_kind = k;
      cycle();
      fill_en = 1'b0;
   endtask

   task automatic drop(bit [31:0] a);
      inv_addr_en = 1'b1; inv_addr = a;
      cycle();
      inv_addr_en = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < N; i++) begin
         m_kind[i] = 0; m_tag[i] = 0; m_pb[i] = 0; m_perm[i] = 0; m_dom[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: empty after reset
      phase = "R1";
      look(32'h0000_0000); look(32'h1234_5678); look(32'hFFFF_FFFF);
      // R4 / R2: one fill per page kind, low bits deliberately dirty
      phase = "R4";
      fill(32'h1000_1ABC, 32'h8000_2FFF, 10'h3A5, 4'h1, 3'd1);
      fill(32'h2003_7123, 32'h9004_5678, 10'h0F0, 4'h2, 3'd2);
      fill(32'h305F_FFFF, 32'hA0AB_CDEF, 10'h111, 4'h3, 3'd3);
      fill(32'h4000_2345, 32'hB000_3FFF, 10'h222, 4'h4, 3'd4);
      fill(32'h5000_0DEF, 32'hC000_07FF, 10'h333, 4'h5, 3'd5);
      fill(32'h6000_0000, 32'hD000_1000, 10'h044, 4'h6, 3'd1);
      fill(32'h7000_0000, 32'hE001_0000, 10'h055, 4'h7, 3'd2);
      fill(32'h0010_0000, 32'hF010_0000, 10'h066, 4'h8, 3'd3);
      phase = "R2";
      look(32'h1000_1FFF); look(32'h1000_2000);
      look(32'h2003_FFF0); look(32'h2004_0000);
      look(32'h3051_2345); look(32'h4000_2FFC);
      look(32'h5000_0C04); look(32'h5000_0BFC);
      // R6: ninth fill wraps to slot 0
      phase = "R6";
      fill(32'h1234_5000, 32'h0777_7000, 10'h1FF, 4'h9, 3'd1);
      look(32'h1234_5678); look(32'h1000_1ABC);
      // R9: section in slot 1 overlaps 64 KiB page in slot 6
      phase = "R9";
      fill(32'h7000_0000, 32'h0200_0000, 10'h2AA, 4'hA, 3'd3);
      look(32'h7000_1234);
      // R8: drop slot 1 only; pointer stays at 2
      phase = "R8";
      drop(32'h7000_5555);
      look(32'h7000_1234);
      fill(32'h0800_0000, 32'h0900_0000, 10'h155, 4'hB, 3'd2);
      look(32'h0800_ABCD); look(32'h3050_0000);
      // R3: invalid and unknown kinds never match
      phase = "R3";
      fill(32'h4000_2000, 32'h1111_1000, 10'h001, 4'hC, 3'd0);
      look(32'h4000_2000);
      fill(32'h5000_0C00, 32'h2222_2C00, 10'h002, 4'hD, 3'd7);
      look(32'h5000_0C00);
      // R11: fill and drop hit slot 5 together; fill wins
      phase = "R11";
      fill_en = 1'b1; fill_vaddr = 32'h0ABC_0000; fill_pbase = 32'h0CD0_0000;
      fill_perm = 10'h3C3; fill_dom = 4'hE; fill_kind = 3'd3;
      inv_addr_en = 1'b1; inv_addr = 32'h6000_0123;
      cycle();
      fill_en = 1'b0; inv_addr_en = 1'b0;
      look(32'h0AB1_2345); look(32'h6000_0123);
      // R7: flush beats a fill in the same cycle
      phase = "R7";
      inv_all = 1'b1; fill_en = 1'b1; fill_kind = 3'd1; fill_vaddr = 32'h1234_5000;
      cycle();
      inv_all = 1'b0; fill_en = 1'b0;
      look(32'h1234_5678); look(32'h7000_1234);
      fill(32'h5555_5000, 32'h6666_6000, 10'h321, 4'hF, 3'd1);
      look(32'h5555_5ABC);
      inv_all = 1'b1; cycle(); inv_all = 1'b0;
      look(32'h5555_5ABC);
      fill(32'h0101_0000, 32'h0202_0000, 10'h004, 4'h3, 3'd2);
      look(32'h0101_FFFF);
      // Random mix
      phase = "R2";
      for (int t = 0; t < 600; t++) begin
         lk_vaddr    = 32'h4000_0000 | ($urandom & 32'h0031_3FFF);
         fill_en     = ($urandom % 10) < 3;
         fill_vaddr  = 32'h4000_0000 | ($urandom & 32'h0031_3FFF);
         fill_pbase  = $urandom;
         fill_perm   = 10'($urandom);
         fill_dom    = 4'($urandom);
         fill_kind   = 3'($urandom % 7);
         inv_addr_en = ($urandom % 10) == 0;
         inv_addr    = 32'h4000_0000 | ($urandom & 32'h0031_3FFF);
         inv_all     = ($urandom % 50) == 0;
         cycle();
      end
      fill_en = 1'b0; inv_addr_en = 1'b0; inv_all = 1'b0;
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired (phase %s) actual=running expected=done", phase);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule